// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block orders two binary floating-point operands, or one operand against zero, and turns the outcome into four condition flags (negative, zero, carry, overflow). Later conditional instructions can test any IEEE 754 comparison predicate from those flags. It also produces an unordered indication and an invalid-operation flag. The operand format is parameterized by exponent and fraction widths. The defaults give single precision.

A compare is launched by pulsing `in_valid` with the operands and two mode selects present. The first select, `cmp_zero`, replaces the second operand with positive zero. The second select, `trap_qnan`, makes the compare signaling, so that quiet NaNs also raise invalid-operation. All six outputs are registered. They take the new result on the clock edge that samples `in_valid` and keep it until the next compare.

Top module: `fcmp_flag_unit`

## Requirements
- R1: While reset is asserted and after its release, before any compare, the flags {N,Z,C,V} read 4'b0000, and `unordered` and `invalid_op` read 0.
- R2: When two ordered operands are equal in value, {N,Z,C,V} becomes 4'b0110.
- R3: When the first operand is less than the second, {N,Z,C,V} becomes 4'b1000.
- R4: When the first operand is greater than the second, {N,Z,C,V} becomes 4'b0010.
- R5: If either compared operand is a NaN, {N,Z,C,V} becomes 4'b0011 and `unordered` becomes 1. A NaN has the exponent field all ones and a nonzero fraction. For every other result `unordered` is 0.
- R6: Positive zero and negative zero compare as equal.
- R7: Infinities are ordered by their sign. Positive infinity is greater than every finite value, negative infinity is less than every finite value, and two infinities of the same sign are equal.
- R8: With `trap_qnan`=0, `invalid_op` is 1 only when a compared operand is a signaling NaN. A signaling NaN is a NaN whose top fraction bit is 0. A quiet NaN, whose top fraction bit is 1, gives an unordered result with `invalid_op`=0.
- R9: With `trap_qnan`=1, any NaN operand sets `invalid_op` to 1, together with an unordered result.
- R10: With `cmp_zero`=1, `op_b` is ignored and `op_a` is compared against positive zero. The same NaN and invalid-operation rules apply.
- R11: The outputs take the new result on the rising edge at which `in_valid` is sampled high. They hold their value through every cycle with `in_valid` low, whatever the operand and select inputs do.
- R12: `invalid_op` is 0 for any compare in which neither operand is a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Launches a compare this cycle |
| op_a | input | EXP_W+MAN_W+1 | First operand: sign, exponent, fraction |
| op_b | input | EXP_W+MAN_W+1 | Second operand; ignored when `cmp_zero` is 1 |
| cmp_zero | input | 1 | Compare `op_a` against positive zero |
| trap_qnan | input | 1 | Signaling compare: quiet NaNs also raise invalid-operation |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| unordered | output | 1 | Result is unordered (a NaN was compared) |
| invalid_op | output | 1 | Invalid-operation raised by this compare |

## Verification
The bench runs the block in a 6-bit format (3 exponent bits, 2 fraction bits). It compares every pair of encodings in both compare variants, and every encoding against zero. Expected results come from an integer model that decodes each encoding to a scaled signed value. That model is independent of the block's sign-magnitude ordering.

The sweep targets specific mistakes:
- A design that compares raw bit patterns would call -0 below +0.
- A design that compares raw bit patterns would order negative values backwards.
- A design that mistakes an infinity for a NaN would report unordered.
- A design that swaps the quiet and signaling rules would raise invalid-operation on the wrong variant.

Separate steps change the operands while `in_valid` is low to catch outputs that fail to hold. They also pass garbage on `op_b` in zero mode to catch an unmasked second operand.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } fcmp_rel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } fcmp_nzcv_t;

  localparam fcmp_nzcv_t NZCV_IDLE = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

  function automatic fcmp_nzcv_t rel_to_nzcv(fcmp_rel_e rel);
    fcmp_nzcv_t f;
    unique case (rel)
      REL_EQ:  f = '{n: 1'b0, z: 1'b1, c: 1'b1, v: 1'b0};
      REL_LT:  f = '{n: 1'b1, z: 1'b0, c: 1'b0, v: 1'b0};
      REL_GT:  f = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b0};
      default: f = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b1};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = EXP_W + MAN_W + 1,
  localparam int MAG_W = W - 1
) (
  input  logic [W-1:0]     op,
  output logic             sign,
  output logic             is_zero,
  output logic             is_nan,
  output logic             is_snan,
  output logic [MAG_W-1:0] mag
);

  function automatic logic exp_all_ones(logic [EXP_W-1:0] e);
    return &e;
  endfunction

  function automatic logic frac_nonzero(logic [MAN_W-1:0] f);
    return |f;
  endfunction

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac_f;

  assign sign    = op[W-1];
  assign exp_f   = op[W-2 -: EXP_W];
  assign frac_f  = op[MAN_W-1:0];
  assign mag     = op[MAG_W-1:0];
  assign is_zero = (mag == '0);
  assign is_nan  = exp_all_ones(exp_f) && frac_nonzero(frac_f);
  assign is_snan = is_nan && !frac_f[MAN_W-1];

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic             a_sign,
  input  logic             a_zero,
  input  logic             a_nan,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic             b_zero,
  input  logic             b_nan,
  input  logic [MAG_W-1:0] b_mag,
  output fcmp_rel_e        rel
);

  function automatic fcmp_rel_e order_of(
    logic sa, logic za, logic na, logic [MAG_W-1:0] ma,
    logic sb, logic zb, logic nb, logic [MAG_W-1:0] mb);
    logic mag_lt;
    if (na || nb)            return REL_UN;
    if (za && zb)            return REL_EQ;
    if (sa != sb)            return sa ? REL_LT : REL_GT;
    if (ma == mb)            return REL_EQ;
    mag_lt = (ma < mb);
    return (mag_lt ^ sa) ? REL_LT : REL_GT;
  endfunction

  assign rel = order_of(a_sign, a_zero, a_nan, a_mag,
                        b_sign, b_zero, b_nan, b_mag);

endmodule

// File: rtl/fcmp_flag_reg.sv
module fcmp_flag_reg
  import fcmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  fcmp_rel_e rel,
  input  logic      inv_in,
  output logic      flag_n,
  output logic      flag_z,
  output logic      flag_c,
  output logic      flag_v,
  output logic      unord,
  output logic      invalid
);

  fcmp_nzcv_t nzcv_q;
  fcmp_nzcv_t nzcv_d;
  logic       unord_q;
  logic       inv_q;

  assign nzcv_d = rel_to_nzcv(rel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nzcv_q  <= NZCV_IDLE;
      unord_q <= 1'b0;
      inv_q   <= 1'b0;
    end else if (load) begin
      nzcv_q  <= nzcv_d;
      unord_q <= (rel == REL_UN);
      inv_q   <= inv_in;
    end
  end

  assign flag_n  = nzcv_q.n;
  assign flag_z  = nzcv_q.z;
  assign flag_c  = nzcv_q.c;
  assign flag_v  = nzcv_q.v;
  assign unord   = unord_q;
  assign invalid = inv_q;

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = EXP_W + MAN_W + 1,
  localparam int MAG_W = W - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         cmp_zero,
  input  logic         trap_qnan,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v,
  output logic         unordered,
  output logic         invalid_op
);

  // second operand after zero-mode substitution
  logic [W-1:0]     op_b_eff;
  logic             a_sign, a_zero, a_nan, a_snan;
  logic             b_sign, b_zero, b_nan, b_snan;
  logic [MAG_W-1:0] a_mag, b_mag;
  fcmp_rel_e        rel_now;
  logic             any_nan, any_snan, inv_now;

  assign op_b_eff = cmp_zero ? '0 : op_b;

  fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
    .op(op_a), .sign(a_sign), .is_zero(a_zero), .is_nan(a_nan),
    .is_snan(a_snan), .mag(a_mag)
  );

  fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
    .op(op_b_eff), .sign(b_sign), .is_zero(b_zero), .is_nan(b_nan),
    .is_snan(b_snan), .mag(b_mag)
  );

  fcmp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a_sign(a_sign), .a_zero(a_zero), .a_nan(a_nan), .a_mag(a_mag),
    .b_sign(b_sign), .b_zero(b_zero), .b_nan(b_nan), .b_mag(b_mag),
    .rel(rel_now)
  );

  assign any_nan  = a_nan | b_nan;
  assign any_snan = a_snan | b_snan;
  assign inv_now  = any_snan | (trap_qnan & any_nan);

  fcmp_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .load(in_valid), .rel(rel_now), .inv_in(inv_now),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .unord(unordered), .invalid(invalid_op)
  );

endmodule

// File: rtl/fcmp_flag_checker.sv
module fcmp_flag_checker #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = EXP_W + MAN_W + 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         cmp_zero,
  input logic         trap_qnan,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_v,
  input logic         unordered,
  input logic         invalid_op
);

  function automatic logic chk_nan(logic [W-1:0] x);
    return (x[W-2 -: EXP_W] == {EXP_W{1'b1}}) && (x[MAN_W-1:0] != '0);
  endfunction

  function automatic logic chk_snan(logic [W-1:0] x);
    return chk_nan(x) && !x[MAN_W-1];
  endfunction

  logic [3:0] code;
  logic       nan_seen;
  logic       snan_seen;
  assign code      = {flag_n, flag_z, flag_c, flag_v};
  assign nan_seen  = chk_nan(op_a) || (!cmp_zero && chk_nan(op_b));
  assign snan_seen = chk_snan(op_a) || (!cmp_zero && chk_snan(op_b));

  p_unord_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unordered == (code == 4'b0011));

  p_nan_unord_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && nan_seen |=> unordered);

  p_snan_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && snan_seen |=> invalid_op);

  p_trap_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && trap_qnan && nan_seen |=> invalid_op);

  p_inv_needs_nan_r12: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_op |-> unordered);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(code) && $stable(unordered) && $stable(invalid_op));

  p_self_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !cmp_zero && (op_a == op_b) && !chk_nan(op_a) |=> code == 4'b0110);

  p_zero_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cmp_zero && (op_a[W-2:0] == '0) |=> code == 4'b0110);

endmodule

bind fcmp_flag_unit fcmp_flag_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fcmp_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .cmp_zero(cmp_zero), .trap_qnan(trap_qnan), .flag_n(flag_n), .flag_z(flag_z),
  .flag_c(flag_c), .flag_v(flag_v), .unordered(unordered), .invalid_op(invalid_op)
);

// File: tb/fcmp_flag_unit_bench.sv
`timescale 1ns/1ps
module fcmp_flag_unit_bench;

  localparam int EW = 3;
  localparam int MW = 2;
  localparam int W  = EW + MW + 1;
  localparam int N  = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         cmp_zero = 1'b0;
  logic         trap_qnan = 1'b0;
  logic         flag_n, flag_z, flag_c, flag_v, unordered, invalid_op;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fcmp_flag_unit #(.EXP_W(EW), .MAN_W(MW)) u_fcmp_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .cmp_zero(cmp_zero), .trap_qnan(trap_qnan), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .unordered(unordered), .invalid_op(invalid_op)
  );

  // scaled integer value of an ordered encoding; infinity maps beyond every finite
  function automatic int value_of(logic [W-1:0] x);
    int e, m, v;
    e = int'(x[W-2 -: EW]);
    m = int'(x[MW-1:0]);
    if (e == 0)              v = m;
    else if (e == (1<<EW)-1) v = 100000;
    else                     v = ((1 << MW) + m) << (e - 1);
    return x[W-1] ? -v : v;
  endfunction

  function automatic bit is_nan(logic [W-1:0] x);
    return (x[W-2 -: EW] == '1) && (x[MW-1:0] != 0);
  endfunction

  function automatic bit is_snan(logic [W-1:0] x);
    return is_nan(x) && !x[MW-1];
  endfunction

  function automatic bit is_inf(logic [W-1:0] x);
    return (x[W-2 -: EW] == '1) && (x[MW-1:0] == 0);
  endfunction

  // expected {N,Z,C,V,unordered,invalid}
  function automatic logic [5:0] expect_of(logic [W-1:0] a, logic [W-1:0] b, bit sig);
    int va, vb;
    if (is_nan(a) || is_nan(b))
      return {4'b0011, 1'b1, (sig | is_snan(a) | is_snan(b))};
    va = value_of(a);
    vb = value_of(b);
    if (va == vb) return {4'b0110, 2'b00};
    if (va < vb)  return {4'b1000, 2'b00};
    return {4'b0010, 2'b00};
  endfunction

  function automatic string req_of(logic [W-1:0] a, logic [W-1:0] b, bit sig, bit zm);
    int va, vb;
    if (zm) return "R10";
    if (is_nan(a) || is_nan(b)) return sig ? "R9" : ((is_snan(a) || is_snan(b)) ? "R8" : "R5");
    if (a[W-2:0] == 0 && b[W-2:0] == 0) return "R6";
    if (is_inf(a) || is_inf(b)) return "R7";
    va = value_of(a);
    vb = value_of(b);
    if (va == vb) return "R2";
    if (va < vb)  return "R3";
    return "R4";
  endfunction

  function automatic logic [5:0] outs();
    return {flag_n, flag_z, flag_c, flag_v, unordered, invalid_op};
  endfunction

  task automatic check(string req, logic [5:0] got, logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // drive at a falling edge, register at the next rising edge, sample at the falling edge after
  task automatic run_cmp(logic [W-1:0] a, logic [W-1:0] b, bit zm, bit sig);
    op_a = a; op_b = b; cmp_zero = zm; trap_qnan = sig; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", outs(), 6'b000000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", outs(), 6'b000000);

    // exhaustive pair sweep, both compare variants
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          run_cmp(W'(i), W'(j), 1'b0, s[0]);
          check(req_of(W'(i), W'(j), s[0], 1'b0), outs(), expect_of(W'(i), W'(j), s[0]));
        end
      end
    end

    // zero mode: op_b carries a varying non-zero pattern that must be ignored
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < N; i++) begin
        logic [W-1:0] junk;
        junk = W'((i * 37 + 11) % N) | W'(1);
        run_cmp(W'(i), junk, 1'b1, s[0]);
        check(req_of(W'(i), '0, s[0], 1'b1), outs(), expect_of(W'(i), '0, s[0]));
      end
    end

    // R11: result appears on the sampling edge and holds while in_valid is low
    for (int k = 0; k < N; k += 5) begin
      logic [5:0] held;
      run_cmp(W'(k), W'(N-1-k), 1'b0, 1'b0);
      held = outs();
      check("R11", held, expect_of(W'(k), W'(N-1-k), 1'b0));
      op_a = W'(N-1-k); op_b = W'(k); cmp_zero = ~cmp_zero; trap_qnan = 1'b1;
      repeat (2) @(negedge clk);
      check("R11", outs(), held);
    end

    // R12: ordered compares in the signaling variant never raise invalid-operation
    run_cmp(6'b111100, 6'b011100, 1'b0, 1'b1);
    check("R12", outs(), {4'b1000, 2'b00});

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule